// File: doc/BRIEF.md
# PCI Interrupt Line Router

This block steers the four shared PCI interrupt lines onto sixteen level-sensitive inputs of an interrupt controller. Each shared line has its own 8-bit routing byte. A routing value of 0 to 15 selects the controller input. A value of 16 or more turns the line off, and the block then ignores its level.

The block holds a presence map with one bit per pair of controller input and shared line, 64 bits in all. Each controller input is the OR of its four map bits. When a shared line changes level, the block updates only that line's bit. Any write that hits a routing byte discards the whole map and rebuilds it from the present line levels under the new routing.

Three further functions are provided:
- A combinational query reports, for one shared line, whether it is routed and to which input.
- A second combinational function maps a device number and INTx pin onto a shared line index.
- A read port returns the routing word, so software and the bench can observe it.

The map update is chosen each cycle by one of three named update kinds, evaluated in priority order:
- REBUILD: a routing write occurred.
- LEVEL: some line level differs from the level captured in the previous cycle.
- HOLD: neither of the above.

Top module: `pirq_router`

## Requirements
- R1: After reset all four routing bytes read 0x80, so every line is disabled. The word at configuration address 0x60 reads 0x80808080, and all sixteen outputs are low.
- R2: The routing bytes sit at byte addresses 0x60 (line 0) to 0x63 (line 3), in lanes 0 to 3 of the word at 0x60. A write changes only the bytes whose byte-enable bit is set. A write to any other word address changes nothing, and reads of other word addresses return zero.
- R3: A routing value below 16 routes the line. While the line is high, output number = routing value is high; values 0 and 15 are both valid.
- R4: A routing value of 16 or more disables the line. Its level then has no effect on any output.
- R5: Each output is the OR of all lines routed to it. The output stays high until every such line is low.
- R6: A routing write that moves a high line moves its output. The old output falls (if no other source drives it), and the new output rises, in the same cycle.
- R7: A level change on one line alters only the output that line is routed to. All other outputs keep their values.
- R8: Outputs are registered and change exactly one clock edge after a level change or a routing write, and not before.
- R9: For the selected line, the route query returns enable=1 and the routing value when the value is below 16. Otherwise it returns enable=0 and 0xFF, which is -1 in 8 bits.
- R10: The swizzle returns (pin + (devfn>>3) - 1) mod 4. For example: devfn 0x08 with pin 0 gives 0; devfn 0x00 with pin 0 gives 3; devfn 0x18 with pin 2 gives 0; devfn 0x2F with pin 1 gives 1.
- R11: Enabling a routing byte while its line is already high raises the selected output right after the write, because the rebuild uses the present levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pirq_level | input | 4 | Level of shared lines 0..3 |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Write byte address (word aligned) |
| cfg_wdata | input | 32 | Write data, lane i = byte i |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_rd_addr | input | 8 | Read byte address (word aligned) |
| cfg_rdata | output | 32 | Read data of the routing word, else zero |
| qry_pin | input | 2 | Line index for the route query |
| qry_en | output | 1 | Queried line is routed |
| qry_irq | output | 8 | Routed input number, or 0xFF when disabled |
| swz_devfn | input | 8 | Device/function number for the swizzle |
| swz_pin | input | 2 | INTx pin (0 = A) for the swizzle |
| swz_pirq | output | 2 | Shared line index from the swizzle |
| irq_out | output | 16 | Level requests to the interrupt controller |

## Verification
Every output change from a level change or a routing write is due exactly one rising edge after the stimulus. The bench drives each stimulus on a falling edge and samples on the next falling edge. For the latency requirement, it also samples shortly after driving, before any rising edge, to show the output has not yet moved. The route query, the swizzle and the read port are combinational, so they are sampled shortly after their inputs settle, with no clock edge in between.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

    // Kind of update applied to the presence map in a cycle
    typedef enum logic [1:0] {
        UPD_HOLD    = 2'd0,
        UPD_LEVEL   = 2'd1,
        UPD_REBUILD = 2'd2
    } upd_kind_e;

    localparam int unsigned DEF_NUM_PIRQ  = 4;
    localparam int unsigned DEF_NUM_IRQ   = 16;
    localparam int unsigned DEF_REG_W     = 8;
    localparam int unsigned DEF_ADDR_W    = 8;
    localparam int unsigned DEF_DATA_W    = 32;

endpackage

// File: rtl/pirq_route_regs.sv
module pirq_route_regs #(
    parameter int unsigned NUM_PIRQ    = 4,
    parameter int unsigned REG_W       = 8,
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned DATA_W      = 32,
    parameter logic [7:0]  ROUTE_BASE  = 8'h60,
    parameter logic [7:0]  RESET_ROUTE = 8'h80
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [DATA_W-1:0]         wr_data,
    input  logic [DATA_W/8-1:0]       wr_be,
    input  logic [ADDR_W-1:0]         rd_addr,
    output logic [DATA_W-1:0]         rd_data,
    output logic [NUM_PIRQ*REG_W-1:0] route_q_flat,
    output logic [NUM_PIRQ*REG_W-1:0] route_d_flat,
    output logic                      write_hit
);

    localparam int unsigned LANES  = DATA_W / 8;
    localparam int unsigned LANE_W = (LANES > 1) ? $clog2(LANES) : 1;

    logic [NUM_PIRQ-1:0]    hit;
    logic [REG_W-1:0]       route_q [NUM_PIRQ];
    logic [REG_W-1:0]       route_d [NUM_PIRQ];
    logic [DATA_W-1:0]      rd_acc  [NUM_PIRQ+1];

    assign rd_acc[0] = '0;

    for (genvar p = 0; p < NUM_PIRQ; p++) begin : g_reg
        localparam logic [ADDR_W-1:0] BYTE_ADDR = ADDR_W'(ROUTE_BASE) + ADDR_W'(p);
        localparam int unsigned        LANE      = int'(BYTE_ADDR) % LANES;

        assign hit[p] = wr_en
                     && (wr_addr[ADDR_W-1:LANE_W] == BYTE_ADDR[ADDR_W-1:LANE_W])
                     && wr_be[LANE];

        always_comb begin
            route_d[p] = route_q[p];
            if (hit[p]) begin
                route_d[p] = wr_data[LANE*8 +: REG_W];
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                route_q[p] <= REG_W'(RESET_ROUTE);
            end else begin
                route_q[p] <= route_d[p];
            end
        end

        always_comb begin
            rd_acc[p+1] = rd_acc[p];
            if (rd_addr[ADDR_W-1:LANE_W] == BYTE_ADDR[ADDR_W-1:LANE_W]) begin
                rd_acc[p+1][LANE*8 +: REG_W] = route_q[p];
            end
        end

        assign route_q_flat[p*REG_W +: REG_W] = route_q[p];
        assign route_d_flat[p*REG_W +: REG_W] = route_d[p];
    end

    assign rd_data   = rd_acc[NUM_PIRQ];
    assign write_hit = |hit;

endmodule

// File: rtl/pirq_level_map.sv
module pirq_level_map
    import pirq_pkg::*;
#(
    parameter int unsigned NUM_PIRQ = 4,
    parameter int unsigned NUM_IRQ  = 16,
    parameter int unsigned REG_W    = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_PIRQ-1:0]       level,
    input  logic [NUM_PIRQ*REG_W-1:0] route_flat,
    input  logic                      rebuild,
    output logic [NUM_IRQ-1:0]        irq_q
);

    localparam int unsigned MAP_W = NUM_IRQ * NUM_PIRQ;
    localparam int unsigned IDX_W = $clog2(NUM_IRQ);

    logic [MAP_W-1:0]    map_q, map_d;
    logic [NUM_PIRQ-1:0] level_q;
    logic [NUM_PIRQ-1:0] route_en;
    logic [IDX_W-1:0]    route_idx [NUM_PIRQ];
    logic [NUM_IRQ-1:0]  irq_d;
    upd_kind_e           kind;

    for (genvar p = 0; p < NUM_PIRQ; p++) begin : g_dec
        assign route_en[p]  = route_flat[p*REG_W +: REG_W] < REG_W'(NUM_IRQ);
        assign route_idx[p] = route_flat[p*REG_W +: IDX_W];
    end

    always_comb begin
        if (rebuild) begin
            kind = UPD_REBUILD;
        end else if (level != level_q) begin
            kind = UPD_LEVEL;
        end else begin
            kind = UPD_HOLD;
        end
    end

    always_comb begin
        map_d = map_q;
        unique case (kind)
            UPD_HOLD: begin
                map_d = map_q;
            end
            UPD_LEVEL: begin
                for (int p = 0; p < NUM_PIRQ; p++) begin
                    if (route_en[p] && (level[p] != level_q[p])) begin
                        map_d[int'(route_idx[p]) * NUM_PIRQ + p] = level[p];
                    end
                end
            end
            UPD_REBUILD: begin
                map_d = '0;
                for (int p = 0; p < NUM_PIRQ; p++) begin
                    if (route_en[p]) begin
                        map_d[int'(route_idx[p]) * NUM_PIRQ + p] = level[p];
                    end
                end
            end
            default: begin
                map_d = map_q;
            end
        endcase
    end

    for (genvar r = 0; r < NUM_IRQ; r++) begin : g_or
        assign irq_d[r] = |map_d[r*NUM_PIRQ +: NUM_PIRQ];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            map_q   <= '0;
            level_q <= '0;
            irq_q   <= '0;
        end else begin
            map_q   <= map_d;
            level_q <= level;
            irq_q   <= irq_d;
        end
    end

endmodule

// File: rtl/pirq_swizzle.sv
module pirq_swizzle #(
    parameter int unsigned NUM_PIRQ = 4,
    parameter int unsigned DEVFN_W  = 8,
    parameter int unsigned FUNC_W   = 3
) (
    input  logic [DEVFN_W-1:0]          devfn,
    input  logic [$clog2(NUM_PIRQ)-1:0] pin,
    output logic [$clog2(NUM_PIRQ)-1:0] pirq
);

    localparam int unsigned PIDX_W = $clog2(NUM_PIRQ);

    logic [DEVFN_W-1:0] slot;
    logic [DEVFN_W-1:0] sum;

    assign slot = devfn >> FUNC_W;
    assign sum  = DEVFN_W'(pin) + slot - DEVFN_W'(1);
    assign pirq = sum[PIDX_W-1:0];

endmodule

// File: rtl/pirq_router.sv
module pirq_router #(
    parameter int unsigned NUM_PIRQ    = 4,
    parameter int unsigned NUM_IRQ     = 16,
    parameter int unsigned REG_W       = 8,
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned DEVFN_W     = 8,
    parameter logic [7:0]  ROUTE_BASE  = 8'h60,
    parameter logic [7:0]  RESET_ROUTE = 8'h80
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_PIRQ-1:0]           pirq_level,
    input  logic                          cfg_wr_en,
    input  logic [ADDR_W-1:0]             cfg_addr,
    input  logic [DATA_W-1:0]             cfg_wdata,
    input  logic [DATA_W/8-1:0]           cfg_be,
    input  logic [ADDR_W-1:0]             cfg_rd_addr,
    output logic [DATA_W-1:0]             cfg_rdata,
    input  logic [$clog2(NUM_PIRQ)-1:0]   qry_pin,
    output logic                          qry_en,
    output logic [REG_W-1:0]              qry_irq,
    input  logic [DEVFN_W-1:0]            swz_devfn,
    input  logic [$clog2(NUM_PIRQ)-1:0]   swz_pin,
    output logic [$clog2(NUM_PIRQ)-1:0]   swz_pirq,
    output logic [NUM_IRQ-1:0]            irq_out
);

    logic [NUM_PIRQ*REG_W-1:0] route_flat;
    logic [NUM_PIRQ*REG_W-1:0] route_next;
    logic                      write_hit;
    logic [REG_W-1:0]          qry_val;

    pirq_route_regs #(
        .NUM_PIRQ    (NUM_PIRQ),
        .REG_W       (REG_W),
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .ROUTE_BASE  (ROUTE_BASE),
        .RESET_ROUTE (RESET_ROUTE)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (cfg_wr_en),
        .wr_addr      (cfg_addr),
        .wr_data      (cfg_wdata),
        .wr_be        (cfg_be),
        .rd_addr      (cfg_rd_addr),
        .rd_data      (cfg_rdata),
        .route_q_flat (route_flat),
        .route_d_flat (route_next),
        .write_hit    (write_hit)
    );

    pirq_level_map #(
        .NUM_PIRQ (NUM_PIRQ),
        .NUM_IRQ  (NUM_IRQ),
        .REG_W    (REG_W)
    ) u_map (
        .clk        (clk),
        .rst_n      (rst_n),
        .level      (pirq_level),
        .route_flat (route_next),
        .rebuild    (write_hit),
        .irq_q      (irq_out)
    );

    pirq_swizzle #(
        .NUM_PIRQ (NUM_PIRQ),
        .DEVFN_W  (DEVFN_W),
        .FUNC_W   (3)
    ) u_swz (
        .devfn (swz_devfn),
        .pin   (swz_pin),
        .pirq  (swz_pirq)
    );

    assign qry_val = route_flat[qry_pin*REG_W +: REG_W];
    assign qry_en  = qry_val < REG_W'(NUM_IRQ);
    assign qry_irq = qry_en ? qry_val : '1;

endmodule

// File: rtl/pirq_router_chk.sv
module pirq_router_chk #(
    parameter int unsigned NUM_PIRQ = 4,
    parameter int unsigned NUM_IRQ  = 16,
    parameter int unsigned REG_W    = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [NUM_PIRQ-1:0]       pirq_level,
    input logic                      cfg_wr_en,
    input logic [NUM_PIRQ*REG_W-1:0] route_flat,
    input logic [NUM_IRQ-1:0]        irq_out
);

    localparam int unsigned IDX_W = $clog2(NUM_IRQ);

    logic [NUM_PIRQ-1:0] en;
    logic [IDX_W-1:0]    idx [NUM_PIRQ];
    logic [NUM_IRQ-1:0]  routed_mask;

    for (genvar p = 0; p < NUM_PIRQ; p++) begin : g_d
        assign en[p]  = route_flat[p*REG_W +: REG_W] < REG_W'(NUM_IRQ);
        assign idx[p] = route_flat[p*REG_W +: IDX_W];
    end

    always_comb begin
        routed_mask = '0;
        for (int p = 0; p < NUM_PIRQ; p++) begin
            if (en[p]) routed_mask[idx[p]] = 1'b1;
        end
    end

    // R8
    quiet_inputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_wr_en && $stable(pirq_level)) |=> $stable(irq_out));

    // R4
    all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en == '0) |-> (irq_out == '0));

    // R5
    unrouted_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out & ~routed_mask) == '0);

    for (genvar p = 0; p < NUM_PIRQ; p++) begin : g_lv
        // R3
        high_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!cfg_wr_en && en[p] && pirq_level[p]) |=> irq_out[idx[p]]);
    end

endmodule

bind pirq_router pirq_router_chk #(
    .NUM_PIRQ (NUM_PIRQ),
    .NUM_IRQ  (NUM_IRQ),
    .REG_W    (REG_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pirq_level (pirq_level),
    .cfg_wr_en  (cfg_wr_en),
    .route_flat (route_flat),
    .irq_out    (irq_out)
);

// File: tb/sim_pirq_router.sv
module sim_pirq_router;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  pirq_level = '0;
    logic        cfg_wr_en = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [3:0]  cfg_be = '0;
    logic [7:0]  cfg_rd_addr = 8'h60;
    logic [31:0] cfg_rdata;
    logic [1:0]  qry_pin = '0;
    logic        qry_en;
    logic [7:0]  qry_irq;
    logic [7:0]  swz_devfn = '0;
    logic [1:0]  swz_pin = '0;
    logic [1:0]  swz_pirq;
    logic [15:0] irq_out;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    always #(CLK_P/2) clk = ~clk;

    pirq_router u0 (
        .clk(clk), .rst_n(rst_n), .pirq_level(pirq_level),
        .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_be(cfg_be), .cfg_rd_addr(cfg_rd_addr), .cfg_rdata(cfg_rdata),
        .qry_pin(qry_pin), .qry_en(qry_en), .qry_irq(qry_irq),
        .swz_devfn(swz_devfn), .swz_pin(swz_pin), .swz_pirq(swz_pirq),
        .irq_out(irq_out)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg_write(logic [7:0] a, logic [31:0] d, logic [3:0] be);
        cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d; cfg_be = be;
        @(negedge clk);
        cfg_wr_en = 1'b0; cfg_be = '0;
    endtask

    task automatic set_levels(logic [3:0] v);
        pirq_level = v;
        @(negedge clk);
    endtask

    task automatic t_reset();
        cfg_rd_addr = 8'h60; #1;
        check("R1 route word", cfg_rdata, 32'h80808080);
        check("R1 outputs", 32'(irq_out), 32'h0);
        qry_pin = 2'd0; #1;
        check("R9 query disabled en", 32'(qry_en), 32'h0);
        check("R9 query disabled irq", 32'(qry_irq), 32'hFF);
    endtask

    task automatic t_disabled_ignored();
        set_levels(4'hF);
        check("R4 disabled lines ignored", 32'(irq_out), 32'h0);
    endtask

    task automatic t_byte_enables();
        cfg_write(8'h60, 32'h0B0A0905, 4'b0101);
        cfg_rd_addr = 8'h60; #1;
        check("R2 partial write", cfg_rdata, 32'h800A8005);
        check("R11 enable while high", 32'(irq_out), 32'h0420);
        cfg_write(8'h64, 32'h00000000, 4'b1111);
        #1;
        check("R2 other word ignored", cfg_rdata, 32'h800A8005);
        check("R2 other word no output change", 32'(irq_out), 32'h0420);
        cfg_rd_addr = 8'h64; #1;
        check("R2 other word reads zero", cfg_rdata, 32'h0);
        cfg_rd_addr = 8'h60;
    endtask

    task automatic t_query();
        qry_pin = 2'd0; #1;
        check("R9 query en", 32'(qry_en), 32'h1);
        check("R9 query irq", 32'(qry_irq), 32'h05);
        qry_pin = 2'd1; #1;
        check("R9 query pin1 disabled", 32'(qry_irq), 32'hFF);
    endtask

    task automatic t_levels();
        cfg_write(8'h60, 32'h03030705, 4'b1111);
        check("R11 rebuild all", 32'(irq_out), 32'h00A8);
        set_levels(4'b0000);
        check("R3 all low", 32'(irq_out), 32'h0);
        set_levels(4'b0010);
        check("R3 line1 to 7", 32'(irq_out), 32'h0080);
        set_levels(4'b1110);
        check("R7 add output 3 only", 32'(irq_out), 32'h0088);
        set_levels(4'b1010);
        check("R5 shared output held", 32'(irq_out), 32'h0088);
        set_levels(4'b0010);
        check("R5 shared output drops", 32'(irq_out), 32'h0080);
    endtask

    task automatic t_reroute();
        cfg_write(8'h60, 32'h00000900, 4'b0010);
        check("R6 move 7 to 9", 32'(irq_out), 32'h0200);
        #1;
        check("R6 readback", cfg_rdata, 32'h03030905);
        cfg_write(8'h60, 32'h00001000, 4'b0010);
        check("R4 value 16 disables", 32'(irq_out), 32'h0);
        qry_pin = 2'd1; #1;
        check("R9 value 16 query", 32'({qry_en, qry_irq}), 32'h0FF);
        cfg_write(8'h60, 32'h00000F00, 4'b0010);
        check("R3 value 15", 32'(irq_out), 32'h8000);
        #1;
        check("R9 value 15 query", 32'({qry_en, qry_irq}), 32'h10F);
        cfg_write(8'h60, 32'h00000000, 4'b0010);
        check("R3 value 0", 32'(irq_out), 32'h0001);
        cfg_write(8'h60, 32'h00000F00, 4'b0010);
    endtask

    task automatic t_latency();
        pirq_level = 4'b0011;
        #1;
        check("R8 no change before edge", 32'(irq_out), 32'h8000);
        @(negedge clk);
        check("R8 change after one edge", 32'(irq_out), 32'h8020);
        set_levels(4'b0010);
        check("R7 other output kept", 32'(irq_out), 32'h8000);
    endtask

    task automatic t_swizzle();
        swz_devfn = 8'h08; swz_pin = 2'd0; #1;
        check("R10 dev1 pinA", 32'(swz_pirq), 32'd0);
        swz_devfn = 8'h00; swz_pin = 2'd0; #1;
        check("R10 dev0 pinA", 32'(swz_pirq), 32'd3);
        swz_devfn = 8'h18; swz_pin = 2'd2; #1;
        check("R10 dev3 pinC", 32'(swz_pirq), 32'd0);
        swz_devfn = 8'h2F; swz_pin = 2'd1; #1;
        check("R10 dev5 fn7 pinB", 32'(swz_pirq), 32'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_disabled_ignored();
        t_byte_enables();
        t_query();
        t_levels();
        t_reroute();
        t_latency();
        t_swizzle();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule